// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block stands between a 32-bit integer datapath and a data memory organised in 32-bit words. For every memory instruction it forms the effective byte address by adding a sign-extended 16-bit displacement to a base register value. It then turns that byte address into a word address and a per-lane write-enable mask, and places store data in the correct byte lanes. It handles both word and byte accesses.

Memory is assumed to have a synchronous read: the word appears on `mem_rdata` one clock after the request. The unit remembers the byte offset and the access size of each load for that cycle. When the word returns, it selects and extends the addressed byte, or passes the word through unchanged.

Lane order is big-endian: byte offset 0 is the most significant byte of the word. A word access whose address is not a multiple of four is flagged and never reaches memory.

Top module: `lsu_be_align`

## Requirements
- R1: The effective address equals `base` plus `disp` sign-extended to 32 bits (modulo 2^32), and `mem_addr` equals that address with its two low bits removed.
- R2: With `op_valid` high, opcode 32 is a byte load, 35 a word load, 40 a byte store and 43 a word store. Any other opcode, or `op_valid` low, gives `mem_req`=0, `mem_we`=0 and `misalign`=0.
- R3: An aligned word store drives `mem_we`=4'b1111 and `mem_wdata`=`st_data`.
- R4: A byte store copies `st_data[7:0]` into all four lanes of `mem_wdata` and sets exactly one bit of `mem_we`, namely bit 3 minus the byte offset (offset 0 sets `mem_we[3]`, which covers bits 31:24).
- R5: One cycle after a byte load, `ld_result` is the byte at `mem_rdata[31-8*off -: 8]`, sign-extended to 32 bits, where `off` is address bits 1:0 of that load.
- R6: One cycle after an aligned word load, `ld_result` equals `mem_rdata`.
- R7: A word access with nonzero address bits 1:0 raises `misalign` in the same cycle, keeps `mem_req` low and `mem_we` at zero, and produces no `ld_valid`.
- R8: `ld_valid` is high in exactly those cycles that follow a cycle with an accepted load (`mem_req`=1 and `mem_we`=0).
- R9: Out of a synchronous active-low reset, `ld_valid` is 0.
- R10: While `ld_valid` is low, `ld_result` is zero.
- R11: An accepted access drives `mem_req` high in the same cycle, with no added latency on the request side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A memory instruction is presented this cycle |
| opcode | input | 6 | Primary opcode of the instruction |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement from the instruction |
| st_data | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word returned by memory, one cycle after a read request |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | 30 | Word address |
| mem_we | output | 4 | Byte-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-aligned store data |
| misalign | output | 1 | Misaligned word access detected |
| ld_valid | output | 1 | Load result valid |
| ld_result | output | 32 | Extended load result |

## Verification
The request side is combinational, so a wrong address sum, lane choice or mask appears on `mem_addr`, `mem_we` or `mem_wdata` in the same cycle the instruction is presented. The only held state is the per-load offset, size and pending bit. If any of these is wrong, the next cycle shows the wrong byte lane, a missing or wrong sign extension, or a `ld_valid` pulse that is missing or spurious. The sweep crosses every byte offset, both access sizes and both directions with displacements that carry, borrow and wrap the address. It also uses read words whose bytes differ in sign, so no lane can be mistaken for another.

// File: rtl/lsu_be_pkg.sv
// Package: shared opcode values and the decoded-access record for the
// big-endian load/store alignment unit. Assumes a 6-bit primary opcode.
package lsu_be_pkg;

    localparam int unsigned OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_LDB = 6'd32;
    localparam logic [OPC_W-1:0] OPC_LDW = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STB = 6'd40;
    localparam logic [OPC_W-1:0] OPC_STW = 6'd43;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      is_word;
    } acc_dec_t;

endpackage

// File: rtl/lsu_decode.sv
// Module: lsu_decode
// Turns a valid opcode into an access kind and size. Assumes opcodes
// other than the four memory ones are not memory accesses.
module lsu_decode
    import lsu_be_pkg::*;
(
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    output acc_dec_t         dec
);

    // Purpose: classify the instruction into kind and size.
    always_comb begin
        dec.kind    = ACC_NONE;
        dec.is_word = 1'b0;
        if (op_valid) begin
            unique case (opcode)
                OPC_LDB: begin dec.kind = ACC_LOAD;  dec.is_word = 1'b0; end
                OPC_LDW: begin dec.kind = ACC_LOAD;  dec.is_word = 1'b1; end
                OPC_STB: begin dec.kind = ACC_STORE; dec.is_word = 1'b0; end
                OPC_STW: begin dec.kind = ACC_STORE; dec.is_word = 1'b1; end
                default: begin dec.kind = ACC_NONE;  dec.is_word = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/lsu_agen.sv
// Module: lsu_agen
// Adds a sign-extended displacement to the base to form the byte address,
// and splits it into word address and byte offset. Wraps modulo 2^ADDR_W.
module lsu_agen #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DISP_W = 16,
    parameter int unsigned OFF_W  = 2
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [DISP_W-1:0]       disp,
    output logic [ADDR_W-OFF_W-1:0] word_addr,
    output logic [OFF_W-1:0]        byte_off
);

    localparam int unsigned EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] eff_addr;

    // Purpose: sign-extend the displacement and form the effective address.
    always_comb begin
        disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
        eff_addr  = base + disp_ext;
        word_addr = eff_addr[ADDR_W-1:OFF_W];
        byte_off  = eff_addr[OFF_W-1:0];
    end

endmodule

// File: rtl/lsu_store_lane.sv
// Module: lsu_store_lane
// Builds the byte-lane write mask and lane-aligned store data. Lane i holds
// bits 8i+7:8i, which is big-endian byte offset LANES-1-i. Assumes 8-bit lanes.
module lsu_store_lane
    import lsu_be_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = DATA_W / 8,
    parameter int unsigned OFF_W  = $clog2(LANES)
) (
    input  acc_dec_t          dec,
    input  logic              misalign,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [DATA_W-1:0] st_data,
    output logic [LANES-1:0]  we,
    output logic [DATA_W-1:0] wdata
);

    logic st_ok;

    // Purpose: a store is issued only when it is not misaligned.
    always_comb st_ok = (dec.kind == ACC_STORE) && !misalign;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int unsigned BOFF = LANES - 1 - i;
        localparam logic [OFF_W-1:0] BOFF_V = BOFF[OFF_W-1:0];

        // Purpose: enable this lane for a word store or a byte store aimed at it.
        always_comb we[i] = st_ok && (dec.is_word || (byte_off == BOFF_V));

        // Purpose: word stores keep lanes; byte stores replicate the low byte.
        always_comb wdata[8*i +: 8] = dec.is_word ? st_data[8*i +: 8] : st_data[7:0];
    end

endmodule

// File: rtl/lsu_load_align.sv
// Module: lsu_load_align
// Holds offset and size of a load for one cycle, then extracts and
// sign-extends the addressed byte (big-endian) from the returned word.
// Assumes memory returns read data exactly one cycle after the request.
module lsu_load_align #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = DATA_W / 8,
    parameter int unsigned OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_issue,
    input  logic              ld_word,
    input  logic [OFF_W-1:0]  ld_off,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_result
);

    logic             pend_q;
    logic             word_q;
    logic [OFF_W-1:0] off_q;
    logic [7:0]       sel_byte;

    // Purpose: record that a load was issued, with its size and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            word_q <= 1'b0;
            off_q  <= '0;
        end else begin
            pend_q <= ld_issue;
            if (ld_issue) begin
                word_q <= ld_word;
                off_q  <= ld_off;
            end
        end
    end

    // Purpose: pick the byte lane named by the stored big-endian offset.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (off_q == OFF_W'(LANES - 1 - i)) sel_byte = mem_rdata[8*i +: 8];
        end
    end

    // Purpose: drive the extended result, zero while no load is returning.
    always_comb begin
        ld_valid = pend_q;
        if (!pend_q)     ld_result = '0;
        else if (word_q) ld_result = mem_rdata;
        else             ld_result = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
    end

endmodule

// File: rtl/lsu_be_align.sv
// Module: lsu_be_align (top)
// Big-endian load/store alignment unit: address generation, misalign
// check, store lane placement and load extraction. Assumes a synchronous
// read memory with one cycle of latency and word-granular addressing.
module lsu_be_align
    import lsu_be_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DISP_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  op_valid,
    input  logic [5:0]                            opcode,
    input  logic [ADDR_W-1:0]                     base,
    input  logic [DISP_W-1:0]                     disp,
    input  logic [DATA_W-1:0]                     st_data,
    input  logic [DATA_W-1:0]                     mem_rdata,
    output logic                                  mem_req,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    mem_addr,
    output logic [DATA_W/8-1:0]                   mem_we,
    output logic [DATA_W-1:0]                     mem_wdata,
    output logic                                  misalign,
    output logic                                  ld_valid,
    output logic [DATA_W-1:0]                     ld_result
);

    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);

    acc_dec_t         dec;
    logic [OFF_W-1:0] byte_off;
    logic             is_mem;
    logic             ld_issue;

    lsu_decode u_dec (
        .op_valid (op_valid),
        .opcode   (opcode),
        .dec      (dec)
    );

    lsu_agen #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W),
        .OFF_W  (OFF_W)
    ) u_agen (
        .base      (base),
        .disp      (disp),
        .word_addr (mem_addr),
        .byte_off  (byte_off)
    );

    // Purpose: flag misaligned word accesses and gate the request.
    always_comb begin
        is_mem   = (dec.kind != ACC_NONE);
        misalign = is_mem && dec.is_word && (byte_off != '0);
        mem_req  = is_mem && !misalign;
        ld_issue = mem_req && (dec.kind == ACC_LOAD);
    end

    lsu_store_lane #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .OFF_W  (OFF_W)
    ) u_st (
        .dec      (dec),
        .misalign (misalign),
        .byte_off (byte_off),
        .st_data  (st_data),
        .we       (mem_we),
        .wdata    (mem_wdata)
    );

    lsu_load_align #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .OFF_W  (OFF_W)
    ) u_ld (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_issue  (ld_issue),
        .ld_word   (dec.is_word),
        .ld_off    (byte_off),
        .mem_rdata (mem_rdata),
        .ld_valid  (ld_valid),
        .ld_result (ld_result)
    );

endmodule

// File: rtl/lsu_be_align_chk.sv
// Module: lsu_be_align_chk
// Port-level properties of lsu_be_align, bound into every instance.
module lsu_be_align_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [5:0]  opcode,
    input logic        mem_req,
    input logic [3:0]  mem_we,
    input logic        misalign,
    input logic        ld_valid,
    input logic [31:0] ld_result
);

    // R4: a byte store writes exactly one lane
    p_byte_store_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 6'd40) |-> $countones(mem_we) == 1);

    // R3: an aligned word store writes all lanes
    p_word_store_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 6'd43 && !misalign) |-> mem_we == 4'b1111);

    // R7: misaligned access never reaches memory
    p_misalign_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_we == 4'b0000 && !mem_req));

    // R8: an accepted load yields a result next cycle
    p_load_returns_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we == 4'b0000) |=> ld_valid);

    // R8: no result without an accepted load
    p_no_spurious_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_we == 4'b0000) |=> !ld_valid);

    // R10: idle result is zero
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> ld_result == 32'd0);

    // R2: no write without a request
    p_write_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != 4'b0000) |-> mem_req);

endmodule

bind lsu_be_align lsu_be_align_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .opcode    (opcode),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .misalign  (misalign),
    .ld_valid  (ld_valid),
    .ld_result (ld_result)
);

// File: tb/lsu_be_align_tb.sv
// Bench for lsu_be_align: sweeps bases, displacements, offsets and all four
// access types; the bench models a one-cycle read memory.
module lsu_be_align_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [5:0]  opcode = 6'd0;
    logic [31:0] base = 32'd0;
    logic [15:0] disp = 16'd0;
    logic [31:0] st_data = 32'd0;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_req;
    logic [29:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata;
    logic        misalign;
    logic        ld_valid;
    logic [31:0] ld_result;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lsu_be_align u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .base(base), .disp(disp), .st_data(st_data), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid),
        .ld_result(ld_result)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Presents one access, checks request side, then the returning cycle.
    task automatic run_op(input logic [5:0] opc, input logic [31:0] b,
                          input logic [15:0] d, input logic [31:0] sd,
                          input logic [31:0] rd);
        logic [31:0] ea;
        logic [1:0]  off;
        bit          is_word, is_load, mis;
        logic [3:0]  exp_we;
        logic [31:0] exp_wd, exp_ld;
        logic [7:0]  bsel;
        ea      = b + {{16{d[15]}}, d};
        off     = ea[1:0];
        is_word = (opc == 6'd35) || (opc == 6'd43);
        is_load = (opc == 6'd32) || (opc == 6'd35);
        mis     = is_word && (off != 2'd0);
        @(negedge clk);
        op_valid = 1'b1; opcode = opc; base = b; disp = d; st_data = sd;
        #1;
        chk(misalign == mis, "R7 misalign", {31'd0, misalign}, {31'd0, mis});
        if (mis) begin
            chk(!mem_req && mem_we == 4'd0, "R7 blocked", {27'd0, mem_req, mem_we}, 32'd0);
        end else begin
            chk(mem_req, "R11 request", {31'd0, mem_req}, 32'd1);
            chk(mem_addr == ea[31:2], "R1 address", {2'd0, mem_addr}, {2'd0, ea[31:2]});
            if (is_load) begin
                chk(mem_we == 4'd0, "R2 load no write", {28'd0, mem_we}, 32'd0);
            end else if (is_word) begin
                chk(mem_we == 4'hF && mem_wdata == sd, "R3 word store",
                    mem_wdata, sd);
            end else begin
                exp_we = 4'b1000 >> off;
                exp_wd = {4{sd[7:0]}};
                chk(mem_we == exp_we, "R4 byte mask", {28'd0, mem_we}, {28'd0, exp_we});
                chk(mem_wdata == exp_wd, "R4 byte data", mem_wdata, exp_wd);
            end
        end
        @(negedge clk);
        op_valid = 1'b0; mem_rdata = rd;
        #1;
        if (is_load && !mis) begin
            bsel   = rd[8*(3-off) +: 8];
            exp_ld = is_word ? rd : {{24{bsel[7]}}, bsel};
            chk(ld_valid, "R8 load valid", {31'd0, ld_valid}, 32'd1);
            chk(ld_result == exp_ld, is_word ? "R6 word load" : "R5 byte load",
                ld_result, exp_ld);
        end else begin
            chk(!ld_valid, "R8 no load valid", {31'd0, ld_valid}, 32'd0);
            chk(ld_result == 32'd0, "R10 idle zero", ld_result, 32'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] bases [3];
        logic [15:0] disps [6];
        logic [5:0]  ops [4];
        logic [5:0]  others [4];
        logic [31:0] pat;
        int k;
        bases  = '{32'h1000_0000, 32'h0000_0012, 32'hFFFF_FFF1};
        disps  = '{16'h0000, 16'h0005, 16'hFFFE, 16'h7FFF, 16'h8000, 16'h0003};
        ops    = '{6'd32, 6'd35, 6'd40, 6'd43};
        others = '{6'd0, 6'd33, 6'd41, 6'd15};
        repeat (3) @(negedge clk);
        #1;
        chk(!ld_valid, "R9 reset valid", {31'd0, ld_valid}, 32'd0);
        chk(ld_result == 32'd0, "R10 reset result", ld_result, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        k = 0;
        foreach (bases[bi]) begin
            foreach (disps[di]) begin
                foreach (ops[oi]) begin
                    pat = 32'hF1238C4D ^ {4{k[7:0]}};
                    run_op(ops[oi], bases[bi], disps[di], 32'hA5B6C7D8 ^ {4{k[7:0]}}, pat);
                    k++;
                end
            end
        end
        // R2: non-memory opcodes and op_valid low
        foreach (others[ni]) begin
            @(negedge clk);
            op_valid = 1'b1; opcode = others[ni]; base = 32'h100; disp = 16'h1;
            #1;
            chk(!mem_req && mem_we == 4'd0 && !misalign, "R2 other opcode",
                {27'd0, mem_req, mem_we}, 32'd0);
        end
        @(negedge clk);
        op_valid = 1'b0; opcode = 6'd35; base = 32'h100; disp = 16'h1;
        #1;
        chk(!mem_req && !misalign, "R2 op_valid low", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        #1;
        chk(!ld_valid, "R8 after idle", {31'd0, ld_valid}, 32'd0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule